// File: doc/BRIEF.md
# Two-Stage Interrupt Flag and Pending Controller

This block turns peripheral interrupt events into interrupt requests for the processor core. It has two cascaded latch-and-mask stages. In the module stage, every peripheral module owns a small group of flag bits. A hardware event pulse sets a flag. Each flag is gated by its own mask bit, and the gated flags of a module are OR-combined into that module's request line. In the core stage, each request line latches a pending bit. A pending bit reaches the core only when the line enable bit for that line is set. The core-side output is registered.

Software reaches the block through a simple single-cycle register bus: a write strobe, a word address, write data and combinational read data. Flags, pending bits and line enables each have two write aliases. Writing a one through the set alias sets that bit, and writing a one through the clear alias clears it. Both aliases read back the current value. Module request line `m` feeds core line `m`. Core lines that have no module behind them can only be made pending by software. The core can also retire a pending bit by pulsing the acknowledge input for that line.

Top module: `irq_flag_pend_ctrl`

## Requirements
- R1: After reset, every flag, mask, pending and line-enable bit reads as zero, and `irq_out` is zero.
- R2: A one on `hw_evt[m*FLAGS_PER_MOD+f]` at a clock edge sets flag `f` of module `m`. The new value is readable from that edge on.
- R3: Address map: module region `bus_addr = {0, m[1:0], s[1:0]}`, core region `bus_addr = {1, xx, s[1:0]}`. In the module region, s=0 is the flag set alias, s=1 the flag clear alias, s=2 the plain read/write mask register and s=3 reads zero and ignores writes. In the core region, s=0 is pending set, s=1 pending clear, s=2 enable set and s=3 enable clear. Reads of s=0/1 return the pending bits, and reads of s=2/3 return the enables.
- R4: A write to a set or clear alias changes only the bits written as one. Bits written as zero keep their value.
- R5: A hardware event and a software clear of the same flag in the same cycle leave the flag set.
- R6: A module's request line is high when at least one of its flags has its mask bit set. A flag whose mask bit is zero never causes a pending bit.
- R7: A high request line sets its pending bit at the next clock edge. The bit holds until it is cleared. If the bit is cleared while the line is still high, the clear takes effect and the bit is set again at the following edge.
- R8: Software sets and clears pending bits through the pending set and pending clear aliases, including on lines with no module behind them.
- R9: Line enables change only through the enable set and enable clear aliases. `irq_out` equals pending AND enable as of the previous clock edge, so it lags the registers by one cycle.
- R10: A one on `irq_ack[l]` clears pending bit `l` at that edge, with the same re-set rule as R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_evt | input | NUM_MODS*FLAGS_PER_MOD | Hardware event pulses, one per flag, grouped by module |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_ack | input | NUM_LINES | Core acknowledge pulses, one per line |
| irq_out | output | NUM_LINES | Registered active requests to the core |

## Verification
The hardest conditions to reach from the ports are the same-cycle collisions. One is a hardware event landing on a flag in the very cycle software clears it. The other is a pending clear or acknowledge arriving while the request line is still high, so the bit must drop for exactly one cycle and then return. The stimulus drives the event and the clear-alias write at the same falling edge, and samples the readback at the next falling edge and the one after. A long phase then mixes sparse events, acknowledges and random writes against a behavioural model that is compared on every clock.

// File: rtl/ifp_pkg.sv
package ifp_pkg;
  localparam int DW = 32;

  typedef enum logic [1:0] {
    MS_FLAG_SET = 2'd0,
    MS_FLAG_CLR = 2'd1,
    MS_MASK     = 2'd2,
    MS_NONE     = 2'd3
  } mod_sel_e;

  typedef enum logic [1:0] {
    CS_PEND_SET = 2'd0,
    CS_PEND_CLR = 2'd1,
    CS_LEN_SET  = 2'd2,
    CS_LEN_CLR  = 2'd3
  } core_sel_e;

  function automatic int idx_w(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ifp_regif.sv
module ifp_regif
  import ifp_pkg::*;
#(
  parameter int NUM_MODS  = 4,
  parameter int FPM       = 4,
  parameter int NUM_LINES = 31,
  parameter int ADDR_W    = 5
) (
  input  logic                    bus_we,
  input  logic [ADDR_W-1:0]       bus_addr,
  output logic [DW-1:0]           bus_rdata,
  input  logic [NUM_MODS*FPM-1:0] flags,
  input  logic [NUM_MODS*FPM-1:0] masks,
  input  logic [NUM_LINES-1:0]    pend,
  input  logic [NUM_LINES-1:0]    len,
  output logic [NUM_MODS-1:0]     flag_set_we,
  output logic [NUM_MODS-1:0]     flag_clr_we,
  output logic [NUM_MODS-1:0]     mask_we,
  output logic                    pend_set_we,
  output logic                    pend_clr_we,
  output logic                    len_set_we,
  output logic                    len_clr_we
);
  localparam int IW = ADDR_W - 3;

  logic          core_hit;
  logic [1:0]    sel;
  logic [IW-1:0] idx;
  logic          mod_valid;

  assign core_hit  = bus_addr[ADDR_W-1];
  assign sel       = bus_addr[1:0];
  assign idx       = bus_addr[ADDR_W-2:2];
  assign mod_valid = (32'(idx) < NUM_MODS);

  always_comb begin
    flag_set_we = '0;
    flag_clr_we = '0;
    mask_we     = '0;
    pend_set_we = 1'b0;
    pend_clr_we = 1'b0;
    len_set_we  = 1'b0;
    len_clr_we  = 1'b0;
    if (bus_we) begin
      if (core_hit) begin
        case (core_sel_e'(sel))
          CS_PEND_SET: pend_set_we = 1'b1;
          CS_PEND_CLR: pend_clr_we = 1'b1;
          CS_LEN_SET:  len_set_we  = 1'b1;
          default:     len_clr_we  = 1'b1;
        endcase
      end else if (mod_valid) begin
        case (mod_sel_e'(sel))
          MS_FLAG_SET: flag_set_we[idx] = 1'b1;
          MS_FLAG_CLR: flag_clr_we[idx] = 1'b1;
          MS_MASK:     mask_we[idx]     = 1'b1;
          default:     ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (core_hit) begin
      if (sel[1]) bus_rdata[NUM_LINES-1:0] = len;
      else        bus_rdata[NUM_LINES-1:0] = pend;
    end else if (mod_valid) begin
      case (mod_sel_e'(sel))
        MS_FLAG_SET,
        MS_FLAG_CLR: bus_rdata[FPM-1:0] = flags[32'(idx)*FPM +: FPM];
        MS_MASK:     bus_rdata[FPM-1:0] = masks[32'(idx)*FPM +: FPM];
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/ifp_flag_bank.sv
module ifp_flag_bank #(
  parameter int FPM = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [FPM-1:0] hw_evt,
  input  logic           set_we,
  input  logic           clr_we,
  input  logic           mask_we,
  input  logic [FPM-1:0] wdata,
  output logic [FPM-1:0] flags,
  output logic [FPM-1:0] mask,
  output logic           line_req
);
  // Event bits win over a clear in the same cycle.
  function automatic logic [FPM-1:0] flag_next(
    logic [FPM-1:0] cur, logic [FPM-1:0] hw,
    logic [FPM-1:0] sb,  logic [FPM-1:0] cb);
    return (cur & ~(cb & ~hw)) | hw | sb;
  endfunction

  logic [FPM-1:0] set_bits;
  logic [FPM-1:0] clr_bits;
  logic [FPM-1:0] gated;

  assign set_bits = set_we ? wdata : '0;
  assign clr_bits = clr_we ? wdata : '0;
  assign gated    = flags & mask;
  assign line_req = |gated;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      mask  <= '0;
    end else begin
      flags <= flag_next(flags, hw_evt, set_bits, clr_bits);
      if (mask_we) mask <= wdata;
    end
  end

  a_r5_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_evt != '0) |=> ((flags & $past(hw_evt)) == $past(hw_evt)));

  a_r4_clear_only_ones: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((flags & $past(clr_bits & ~hw_evt)) == '0));

  a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we && hw_evt == '0) |=> (flags == $past(flags)));
endmodule

// File: rtl/ifp_pend_stage.sv
module ifp_pend_stage #(
  parameter int NUM_LINES = 31
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_req,
  input  logic [NUM_LINES-1:0] ack,
  input  logic                 pend_set_we,
  input  logic                 pend_clr_we,
  input  logic                 len_set_we,
  input  logic                 len_clr_we,
  input  logic [NUM_LINES-1:0] wdata,
  output logic [NUM_LINES-1:0] pend,
  output logic [NUM_LINES-1:0] len,
  output logic [NUM_LINES-1:0] irq_out
);
  // A clear in the same cycle wins; a line still high re-sets next edge.
  function automatic logic [NUM_LINES-1:0] pend_next(
    logic [NUM_LINES-1:0] cur, logic [NUM_LINES-1:0] sb,
    logic [NUM_LINES-1:0] cb);
    return (cur | sb) & ~cb;
  endfunction

  logic [NUM_LINES-1:0] sw_set_bits;
  logic [NUM_LINES-1:0] sw_clr_bits;
  logic [NUM_LINES-1:0] clr_bits;
  logic [NUM_LINES-1:0] set_bits;
  logic [NUM_LINES-1:0] len_set_bits;
  logic [NUM_LINES-1:0] len_clr_bits;
  logic [NUM_LINES-1:0] active;

  assign sw_set_bits  = pend_set_we ? wdata : '0;
  assign sw_clr_bits  = pend_clr_we ? wdata : '0;
  assign clr_bits     = sw_clr_bits | ack;
  assign set_bits     = sw_set_bits | line_req;
  assign len_set_bits = len_set_we ? wdata : '0;
  assign len_clr_bits = len_clr_we ? wdata : '0;
  assign active       = pend & len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      len     <= '0;
      irq_out <= '0;
    end else begin
      pend    <= pend_next(pend, set_bits, clr_bits);
      len     <= (len & ~len_clr_bits) | len_set_bits;
      irq_out <= active;
    end
  end

  a_r7_line_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
    ((line_req & ~clr_bits) != '0) |=>
      ((pend & $past(line_req & ~clr_bits)) == $past(line_req & ~clr_bits)));

  a_r7_pend_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend) & ~$past(line_req) & ~$past(sw_set_bits)) == '0));

  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack != '0) |=> ((pend & $past(ack)) == '0));

  a_r9_out_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_out & ~$past(len)) == '0));
endmodule

// File: rtl/irq_flag_pend_ctrl.sv
module irq_flag_pend_ctrl
  import ifp_pkg::*;
#(
  parameter int NUM_MODS      = 4,
  parameter int FLAGS_PER_MOD = 4,
  parameter int NUM_LINES     = 31,
  localparam int ADDR_W       = ifp_pkg::idx_w(NUM_MODS) + 3,
  localparam int NFLAGS       = NUM_MODS * FLAGS_PER_MOD
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NFLAGS-1:0]    hw_evt,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  input  logic [NUM_LINES-1:0] irq_ack,
  output logic [NUM_LINES-1:0] irq_out
);
  logic [NFLAGS-1:0]    flags;
  logic [NFLAGS-1:0]    masks;
  logic [NUM_MODS-1:0]  mod_line;
  logic [NUM_LINES-1:0] line_req;
  logic [NUM_LINES-1:0] pend;
  logic [NUM_LINES-1:0] len;
  logic [NUM_MODS-1:0]  flag_set_we;
  logic [NUM_MODS-1:0]  flag_clr_we;
  logic [NUM_MODS-1:0]  mask_we;
  logic                 pend_set_we;
  logic                 pend_clr_we;
  logic                 len_set_we;
  logic                 len_clr_we;
  logic                 unused_wdata;

  assign unused_wdata = ^bus_wdata;

  ifp_regif #(
    .NUM_MODS(NUM_MODS), .FPM(FLAGS_PER_MOD),
    .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)
  ) u_regif (
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .flags(flags), .masks(masks), .pend(pend), .len(len),
    .flag_set_we(flag_set_we), .flag_clr_we(flag_clr_we), .mask_we(mask_we),
    .pend_set_we(pend_set_we), .pend_clr_we(pend_clr_we),
    .len_set_we(len_set_we), .len_clr_we(len_clr_we)
  );

  for (genvar m = 0; m < NUM_MODS; m++) begin : g_mod
    ifp_flag_bank #(.FPM(FLAGS_PER_MOD)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .hw_evt(hw_evt[m*FLAGS_PER_MOD +: FLAGS_PER_MOD]),
      .set_we(flag_set_we[m]), .clr_we(flag_clr_we[m]), .mask_we(mask_we[m]),
      .wdata(bus_wdata[FLAGS_PER_MOD-1:0]),
      .flags(flags[m*FLAGS_PER_MOD +: FLAGS_PER_MOD]),
      .mask(masks[m*FLAGS_PER_MOD +: FLAGS_PER_MOD]),
      .line_req(mod_line[m])
    );
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    if (l < NUM_MODS) begin : g_fed
      assign line_req[l] = mod_line[l];
    end else begin : g_soft
      assign line_req[l] = 1'b0;
    end
  end

  ifp_pend_stage #(.NUM_LINES(NUM_LINES)) u_pend (
    .clk(clk), .rst_n(rst_n), .line_req(line_req), .ack(irq_ack),
    .pend_set_we(pend_set_we), .pend_clr_we(pend_clr_we),
    .len_set_we(len_set_we), .len_clr_we(len_clr_we),
    .wdata(bus_wdata[NUM_LINES-1:0]),
    .pend(pend), .len(len), .irq_out(irq_out)
  );

  a_r6_masked_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_set_we && mod_line == '0) |=>
      ((pend[NUM_MODS-1:0] & ~$past(pend[NUM_MODS-1:0])) == '0));
endmodule

// File: tb/tb_irq_flag_pend_ctrl.sv
module tb_irq_flag_pend_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] hw_evt = '0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  logic [30:0] irq_ack = '0;
  wire  [30:0] irq_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  irq_flag_pend_ctrl dut (
    .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_ack(irq_ack), .irq_out(irq_out)
  );

  always #10 clk = ~clk;

  // Behavioural reference state
  bit [3:0]  m_flag [4];
  bit [3:0]  m_mask [4];
  bit [30:0] m_pend = '0;
  bit [30:0] m_len  = '0;
  bit [30:0] m_out  = '0;

  always @(posedge clk) begin : model
    bit [30:0] line;
    bit [30:0] ps, pc, ls, lc;
    bit [3:0]  sb, cb, hb;
    if (!rst_n) begin
      for (int m = 0; m < 4; m++) begin m_flag[m] = 0; m_mask[m] = 0; end
      m_pend = 0; m_len = 0; m_out = 0;
    end else begin
      line = 0;
      for (int m = 0; m < 4; m++) line[m] = |(m_flag[m] & m_mask[m]);
      ps = 0; pc = 0; ls = 0; lc = 0;
      if (bus_we && bus_addr[4]) begin
        if (bus_addr[1:0] == 0) ps = bus_wdata[30:0];
        if (bus_addr[1:0] == 1) pc = bus_wdata[30:0];
        if (bus_addr[1:0] == 2) ls = bus_wdata[30:0];
        if (bus_addr[1:0] == 3) lc = bus_wdata[30:0];
      end
      m_out = m_pend & m_len;
      for (int m = 0; m < 4; m++) begin
        sb = 0; cb = 0;
        hb = hw_evt[m*4 +: 4];
        if (bus_we && !bus_addr[4] && bus_addr[3:2] == m[1:0]) begin
          if (bus_addr[1:0] == 0) sb = bus_wdata[3:0];
          if (bus_addr[1:0] == 1) cb = bus_wdata[3:0];
          if (bus_addr[1:0] == 2) m_mask[m] = bus_wdata[3:0];
        end
        for (int f = 0; f < 4; f++) begin
          if (hb[f] || sb[f]) m_flag[m][f] = 1'b1;
          else if (cb[f])     m_flag[m][f] = 1'b0;
        end
      end
      for (int l = 0; l < 31; l++) begin
        if (pc[l] || irq_ack[l])  m_pend[l] = 1'b0;
        else if (line[l] || ps[l]) m_pend[l] = 1'b1;
        if (ls[l]) m_len[l] = 1'b1;
        else if (lc[l]) m_len[l] = 1'b0;
      end
    end
  end

  function automatic logic [31:0] model_rd(logic [4:0] a);
    logic [31:0] r;
    r = '0;
    if (a[4]) r[30:0] = a[1] ? m_len : m_pend;
    else if (a[1:0] <= 2'd1) r[3:0] = m_flag[a[3:2]];
    else if (a[1:0] == 2'd2) r[3:0] = m_mask[a[3:2]];
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Every-cycle comparison of the core request vector
  always @(negedge clk) if (!done) chk("R9 irq_out vs model", {1'b0, irq_out}, {1'b0, m_out});

  function automatic logic [4:0] maddr(int m, int s);
    return {1'b0, 2'(m), 2'(s)};
  endfunction
  function automatic logic [4:0] caddr(int s);
    return {1'b1, 2'b00, 2'(s)};
  endfunction

  task automatic wr(logic [4:0] a, logic [31:0] d, logic [15:0] ev = '0);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; hw_evt = ev;
    @(negedge clk);
    bus_we = 1'b0; hw_evt = '0;
  endtask

  task automatic rd(logic [4:0] a, string tag);
    bus_we = 1'b0; bus_addr = a;
    #1;
    chk(tag, bus_rdata, model_rd(a));
  endtask

  task automatic rd_exp(logic [4:0] a, logic [31:0] exp, string tag);
    bus_we = 1'b0; bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
    chk(tag, bus_rdata, model_rd(a));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_up;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    idle(3);
    chk("R1 irq_out in reset", {1'b0, irq_out}, 32'h0);
    rst_n = 1'b1;
    idle(1);
    // R1: everything reads zero after reset
    for (int a = 0; a < 32; a++) rd_exp(5'(a), 32'h0, "R1 reset readback");

    // R2: hardware event sets a flag; mask zero so nothing goes pending (R6)
    @(negedge clk); hw_evt = 16'h0040;   // module 1, flag 2
    @(negedge clk); hw_evt = '0;
    rd_exp(maddr(1, 0), 32'h4, "R2 event sets flag");
    rd_exp(maddr(1, 1), 32'h4, "R2 flag via clear alias read");
    idle(2);
    rd_exp(caddr(0), 32'h0, "R6 masked flag no pending");

    // R4: set/clear aliases touch only bits written as one
    wr(maddr(0, 0), 32'h5);
    rd_exp(maddr(0, 0), 32'h5, "R4 set alias");
    wr(maddr(0, 1), 32'h1);
    rd_exp(maddr(0, 0), 32'h4, "R4 clear alias one bit");
    wr(maddr(0, 1), 32'h0);
    rd_exp(maddr(0, 0), 32'h4, "R4 clear zero no effect");
    wr(maddr(0, 0), 32'h0);
    rd_exp(maddr(0, 1), 32'h4, "R4 set zero no effect");

    // R5: event and software clear on the same flag in the same cycle
    wr(maddr(2, 0), 32'h2);
    wr(maddr(2, 1), 32'hF, 16'h0100);   // module 2 flag 0 event with clear of all
    rd_exp(maddr(2, 0), 32'h1, "R5 event beats clear");

    // R3: reserved slot reads zero and ignores writes
    wr(maddr(2, 3), 32'hF);
    rd_exp(maddr(2, 3), 32'h0, "R3 reserved slot");
    rd_exp(maddr(2, 0), 32'h1, "R3 reserved write no effect");

    // R6/R7: unmask module 2 -> line 2 goes pending
    wr(maddr(2, 2), 32'h1);
    rd_exp(maddr(2, 2), 32'h1, "R3 mask readback");
    idle(1);
    rd_exp(caddr(0), 32'h4, "R7 line sets pending");
    wr(caddr(2), 32'h4);
    rd_exp(caddr(3), 32'h4, "R9 enable set");
    idle(2);
    chk("R9 irq_out active", {1'b0, irq_out}, 32'h4);

    // R7: clear while line still high -> drops one cycle then returns
    wr(caddr(1), 32'h4);
    rd_exp(caddr(0), 32'h0, "R7 clear wins this edge");
    @(negedge clk);
    rd_exp(caddr(0), 32'h4, "R7 re-set next edge");

    // R10: ack with line still high, then with the line dropped
    @(negedge clk); irq_ack = 31'h4;
    @(negedge clk); irq_ack = '0;
    rd_exp(caddr(1), 32'h0, "R10 ack clears");
    @(negedge clk);
    rd_exp(caddr(1), 32'h4, "R10 re-set after ack");
    wr(maddr(2, 1), 32'h1);
    @(negedge clk); irq_ack = 31'h4;
    @(negedge clk); irq_ack = '0;
    idle(2);
    rd_exp(caddr(0), 32'h0, "R10 ack sticks when line low");
    chk("R9 irq_out after ack", {1'b0, irq_out}, 32'h0);

    // R8: software pending on a line with no module
    wr(caddr(0), 32'h4000_0000);
    rd_exp(caddr(0), 32'h4000_0000, "R8 pending set alias");
    wr(caddr(2), 32'h4000_0000);
    idle(2);
    chk("R9 soft line active", {1'b0, irq_out}, 32'h4000_0004 & 32'h4000_0000);
    wr(caddr(3), 32'h4000_0000);
    rd_exp(caddr(2), 32'h4, "R9 enable clear alias");
    wr(caddr(1), 32'h4000_0000);
    rd_exp(caddr(0), 32'h0, "R8 pending clear alias");
    idle(2);

    // Mixed random traffic against the model
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      hw_evt    = ($urandom_range(0, 3) == 0) ? 16'(1 << $urandom_range(0, 15)) : '0;
      irq_ack   = ($urandom_range(0, 5) == 0) ? 31'(1 << $urandom_range(0, 30)) : '0;
      bus_we    = ($urandom_range(0, 2) == 0);
      bus_addr  = 5'($urandom);
      bus_wdata = $urandom;
      #1;
      chk("R3 random readback", bus_rdata, model_rd(bus_addr));
    end
    @(negedge clk);
    bus_we = 1'b0; hw_evt = '0; irq_ack = '0;
    idle(3);
    for (int a = 0; a < 32; a++) rd(5'(a), "R4 final readback");
    finish_up();
  end
endmodule